// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a CPU interrupt after a programmed number of displayed video lines. Software loads an 8-bit count and an 8-bit reload value through a small set of write-only registers, and it can switch the interrupt on and off. Each line strobe from the video side moves the count down, but only on a visible line, while rendering is on, while the interrupt is enabled and while no request is already pending.

When a line finds the count already at zero, the block sets its request, holds the interrupt line active, and loads the count again from the reload value. The request stays up, and the count stays frozen, until software writes any one of the four interrupt registers. Line 0 is special: a nonzero count takes one extra step down before the normal zero test on that line.

Register writes arrive as a write enable, a 16-bit address and a data byte. Only address bits 15..8 and bit 0 are decoded, and address bit 11 is ignored.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the interrupt output is inactive (low), the enable is off, and the count and reload value are zero, so strobes do nothing until the enable command is written.
- R2: A write whose address masked with 0xFF01 equals 0xC000 or 0xC800 loads the data byte straight into the count.
- R3: A write whose masked address equals 0xC001 or 0xC801 loads the data byte into the reload value and leaves the count alone.
- R4: A write whose masked address equals 0xE000 or 0xE800 turns the interrupt off, so later strobes neither count nor raise a request.
- R5: A write whose masked address equals 0xE001 or 0xE801 turns the interrupt on.
- R6: A write to any of these eight masked addresses clears a pending request, and the output is inactive from the next cycle.
- R7: A strobe counts only if the line number is 239 or less, render_en is high, the interrupt is on and no request is pending.
- R8: On line 0 a nonzero count first drops by one, and the zero test then uses the lowered value.
- R9: A counting strobe that finds the count at zero sets the request (the output goes active, high, in the following cycle) and reloads the count from the reload value. Otherwise the count drops by one.
- R10: While a request is pending, the count holds its value and the output stays active.
- R11: A strobe in the same cycle as a write to one of the eight masked addresses is ignored.
- R12: A write whose masked address is not one of the eight has no effect: the request, the enable, the count and the reload value all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| line_strobe | input | 1 | One-cycle pulse per scanline |
| line_num | input | 8 | Line number that comes with the strobe |
| render_en | input | 1 | High while rendering is on |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The hardest case to reach from the ports is a line-0 strobe that arrives with the count at exactly one, so that the extra step and the zero test together fire on a single strobe. Equally hard is a strobe that coincides with a register write, where the write has to win. Directed sequences load the count through the mirrored addresses and then place the strobe on line 0, or in the same cycle as a write. A long seeded random run mixes writes to decoded and undecoded addresses with strobes on lines above and below the visible limit. A bench model predicts the output on every cycle of that run.

// File: rtl/scnirq_pkg.sv
package scnirq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_COUNT,
      SEL_RELOAD,
      SEL_OFF,
      SEL_ON
   } reg_sel_e;

   typedef struct packed {
      logic ld_count;
      logic ld_reload;
      logic irq_off;
      logic irq_on;
   } wr_cmd_t;

endpackage

// File: rtl/scnirq_decode.sv
module scnirq_decode
   import scnirq_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter logic [7:0]  PAGE_COUNT  = 8'hC0,
   parameter logic [7:0]  PAGE_ENABLE = 8'hE0,
   parameter logic [7:0]  MIRROR_MASK = 8'h08
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output wr_cmd_t           cmd,
   output logic              any_hit
);
   localparam int TOP_LSB = ADDR_W - 8;

   logic [7:0] page;
   logic       odd;
   logic       addr_unused;
   reg_sel_e   sel;

   assign page        = wr_addr[ADDR_W-1:TOP_LSB] & ~MIRROR_MASK;
   assign odd         = wr_addr[0];
   assign addr_unused = ^wr_addr[TOP_LSB-1:1];

   always_comb begin
      sel = SEL_NONE;
      if (wr_en) begin
         if (page == (PAGE_COUNT & ~MIRROR_MASK))
            sel = odd ? SEL_RELOAD : SEL_COUNT;
         else if (page == (PAGE_ENABLE & ~MIRROR_MASK))
            sel = odd ? SEL_ON : SEL_OFF;
      end
   end

   always_comb begin
      cmd           = '0;
      cmd.ld_count  = (sel == SEL_COUNT);
      cmd.ld_reload = (sel == SEL_RELOAD);
      cmd.irq_off   = (sel == SEL_OFF);
      cmd.irq_on    = (sel == SEL_ON);
   end

   assign any_hit = (sel != SEL_NONE);

endmodule

// File: rtl/scnirq_count.sv
module scnirq_count #(
   parameter int CNT_W            = 8,
   parameter bit EXTRA_FIRST_LINE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_count,
   input  logic             ld_reload,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             tick,
   input  logic             first_line,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] reload_q,
   output logic             fire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] adj;
   logic [CNT_W-1:0] cnt_d;

   generate
      if (EXTRA_FIRST_LINE) begin : g_extra
         assign adj = (first_line && (cnt_q != '0)) ? cnt_q - ONE : cnt_q;
      end else begin : g_plain
         logic first_unused;
         assign first_unused = first_line;
         assign adj          = cnt_q;
      end
   endgenerate

   assign fire = tick && (adj == '0);

   always_comb begin
      cnt_d = cnt_q;
      if (ld_count)
         cnt_d = ld_val;
      else if (tick)
         cnt_d = (adj == '0) ? reload_q : adj - ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (ld_reload)
            reload_q <= ld_val;
      end
   end

endmodule

// File: rtl/scnirq_req.sv
module scnirq_req (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en_on,
   input  logic en_off,
   output logic req_q,
   output logic en_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         if (clr)
            req_q <= 1'b0;
         else if (set)
            req_q <= 1'b1;
         if (en_off)
            en_q <= 1'b0;
         else if (en_on)
            en_q <= 1'b1;
      end
   end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
   import scnirq_pkg::*;
#(
   parameter int  ADDR_W           = 16,
   parameter int  DATA_W           = 8,
   parameter int  CNT_W            = 8,
   parameter int  LINE_W           = 8,
   parameter int  LAST_LINE        = 239,
   parameter bit  EXTRA_FIRST_LINE = 1'b1,
   parameter bit  IRQ_ACTIVE_HIGH  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_strobe,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_en,
   output logic              irq
);
   localparam logic [LINE_W-1:0] LAST_L = LINE_W'(LAST_LINE);

   generate
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must be at least 9");
      end
      if (DATA_W < CNT_W) begin : g_bad_data
         $error("DATA_W must cover CNT_W");
      end
      if (LAST_LINE >= (1 << LINE_W)) begin : g_bad_line
         $error("LAST_LINE does not fit LINE_W");
      end
   endgenerate

   wr_cmd_t          cmd;
   logic             any_hit;
   logic             tick;
   logic             fire;
   logic             req_q;
   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic [DATA_W-1:0] data_unused;

   assign data_unused = wr_data;

   scnirq_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .cmd     (cmd),
      .any_hit (any_hit)
   );

   assign tick = line_strobe && !any_hit && render_en &&
                 (line_num <= LAST_L) && en_q && !req_q;

   scnirq_count #(.CNT_W(CNT_W), .EXTRA_FIRST_LINE(EXTRA_FIRST_LINE)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_count   (cmd.ld_count),
      .ld_reload  (cmd.ld_reload),
      .ld_val     (wr_data[CNT_W-1:0]),
      .tick       (tick),
      .first_line (line_num == '0),
      .cnt_q      (cnt_q),
      .reload_q   (reload_q),
      .fire       (fire)
   );

   scnirq_req u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (fire),
      .clr    (any_hit),
      .en_on  (cmd.irq_on),
      .en_off (cmd.irq_off),
      .req_q  (req_q),
      .en_q   (en_q)
   );

   generate
      if (IRQ_ACTIVE_HIGH) begin : g_pos
         assign irq = req_q;
      end else begin : g_neg
         assign irq = ~req_q;
      end
   endgenerate

endmodule

// File: rtl/scnirq_checker.sv
module scnirq_checker #(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter int CNT_W           = 8,
   parameter int LINE_W          = 8,
   parameter int LAST_LINE       = 239,
   parameter bit IRQ_ACTIVE_HIGH = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              line_strobe,
   input logic [LINE_W-1:0] line_num,
   input logic              render_en,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  reload_q,
   input logic              en_q,
   input logic              req_q
);
   logic [7:0] pg;
   logic       c_pg, e_pg, w_cnt, w_rel, w_off, w_on, w_any, qual;

   assign pg    = wr_addr[ADDR_W-1 -: 8];
   assign c_pg  = (pg == 8'hC0) || (pg == 8'hC8);
   assign e_pg  = (pg == 8'hE0) || (pg == 8'hE8);
   assign w_cnt = wr_en && c_pg && !wr_addr[0];
   assign w_rel = wr_en && c_pg &&  wr_addr[0];
   assign w_off = wr_en && e_pg && !wr_addr[0];
   assign w_on  = wr_en && e_pg &&  wr_addr[0];
   assign w_any = w_cnt || w_rel || w_off || w_on;
   assign qual  = line_strobe && !w_any && render_en && en_q && !req_q &&
                  (int'(line_num) <= LAST_LINE);

   p_load_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      w_cnt |=> cnt_q == $past(wr_data[CNT_W-1:0]));

   p_load_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      w_rel |=> reload_q == $past(wr_data[CNT_W-1:0]) && $stable(cnt_q));

   p_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      w_off |=> !en_q);

   p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      w_on |=> en_q);

   p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      w_any |=> irq == !IRQ_ACTIVE_HIGH);

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_cnt && !qual) |=> $stable(cnt_q));

   p_fire_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && cnt_q == '0) |=> req_q && cnt_q == $past(reload_q));

   p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(qual));

   p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !w_cnt) |=> $stable(cnt_q));

   p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (w_any && line_strobe) |=> !req_q);

endmodule

bind scanline_irq_counter scnirq_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LINE_W(LINE_W),
   .LAST_LINE(LAST_LINE), .IRQ_ACTIVE_HIGH(IRQ_ACTIVE_HIGH)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .line_strobe(line_strobe), .line_num(line_num),
   .render_en(render_en), .irq(irq), .cnt_q(cnt_q), .reload_q(reload_q),
   .en_q(en_q), .req_q(req_q)
);

// File: tb/scanline_irq_counter_tb_top.sv
module scanline_irq_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        line_strobe = 1'b0;
   logic [7:0]  line_num = '0;
   logic        render_en = 1'b0;
   logic        irq;

   int total = 0;
   int bad   = 0;

   logic [7:0] m_cnt = '0;
   logic [7:0] m_lat = '0;
   bit         m_en  = 1'b0;
   bit         m_req = 1'b0;

   always #5 clk = ~clk;

   scanline_irq_counter dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .line_strobe(line_strobe), .line_num(line_num),
      .render_en(render_en), .irq(irq)
   );

   function automatic bit is_hit(input logic [15:0] a);
      logic [15:0] m;
      m = a & 16'hFF01;
      return (m == 16'hC000) || (m == 16'hC800) || (m == 16'hC001) ||
             (m == 16'hC801) || (m == 16'hE000) || (m == 16'hE800) ||
             (m == 16'hE001) || (m == 16'hE801);
   endfunction

   task automatic model(input bit w, input logic [15:0] a, input logic [7:0] d,
                        input bit s, input logic [7:0] ln, input bit r);
      logic [15:0] m;
      logic [7:0]  c;
      m = a & 16'hFF01;
      if (w && is_hit(a)) begin
         m_req = 1'b0;
         if (m == 16'hC000 || m == 16'hC800) m_cnt = d;
         if (m == 16'hC001 || m == 16'hC801) m_lat = d;
         if (m == 16'hE000 || m == 16'hE800) m_en = 1'b0;
         if (m == 16'hE001 || m == 16'hE801) m_en = 1'b1;
      end else if (s && r && ln <= 8'd239 && m_en && !m_req) begin
         c = m_cnt;
         if (ln == 8'd0 && c != 8'd0) c = c - 8'd1;
         if (c == 8'd0) begin
            m_req = 1'b1;
            m_cnt = m_lat;
         end else begin
            m_cnt = c - 8'd1;
         end
      end
   endtask

   task automatic check(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: irq=%0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic step(input bit w, input logic [15:0] a, input logic [7:0] d,
                       input bit s, input logic [7:0] ln, input bit r,
                       input string tag);
      wr_en = w; wr_addr = a; wr_data = d;
      line_strobe = s; line_num = ln; render_en = r;
      model(w, a, d, s, ln, r);
      @(negedge clk);
      check(irq, m_req, tag);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
      step(1'b1, a, d, 1'b0, 8'd0, 1'b1, tag);
   endtask

   task automatic ln_strobe(input logic [7:0] ln, input bit r, input string tag);
      step(1'b0, 16'h0000, 8'h00, 1'b1, ln, r, tag);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog: irq=%0b expected finish", irq);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] pool [12];
      pool = '{16'hC000, 16'hC800, 16'hC001, 16'hC801, 16'hE000, 16'hE800,
               16'hE001, 16'hE801, 16'hC0FE, 16'hA000, 16'hD000, 16'hC100};
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(irq, 1'b0, "R1 reset");
      // R1: enable off after reset, so a zero count does not fire
      ln_strobe(8'd10, 1'b1, "R1");
      ln_strobe(8'd11, 1'b1, "R1");
      // R3 R5 R2 setup
      wr(16'hC001, 8'd3, "R3");
      wr(16'hE001, 8'd0, "R5");
      wr(16'hC000, 8'd2, "R2");
      ln_strobe(8'd5, 1'b1, "R9");
      ln_strobe(8'd6, 1'b1, "R9");
      ln_strobe(8'd7, 1'b1, "R9 fire");
      ln_strobe(8'd8, 1'b1, "R10");
      ln_strobe(8'd9, 1'b1, "R10");
      wr(16'hE801, 8'd0, "R6");
      for (int i = 0; i < 4; i++) ln_strobe(8'(20 + i), 1'b1, "R9 reload");
      // R7 qualification
      wr(16'hE001, 8'd0, "R6");
      wr(16'hC800, 8'd0, "R2");
      ln_strobe(8'd240, 1'b1, "R7 line");
      ln_strobe(8'd250, 1'b1, "R7 line");
      ln_strobe(8'd100, 1'b0, "R7 render");
      ln_strobe(8'd239, 1'b1, "R7 last");
      // R8 line 0
      wr(16'hC001, 8'd5, "R6");
      wr(16'hC000, 8'd1, "R2");
      ln_strobe(8'd0, 1'b1, "R8 one");
      wr(16'hC000, 8'd2, "R6");
      ln_strobe(8'd0, 1'b1, "R8 two");
      ln_strobe(8'd1, 1'b1, "R8 two");
      wr(16'hC000, 8'd0, "R6");
      ln_strobe(8'd0, 1'b1, "R8 zero");
      // R11 R12
      wr(16'hC000, 8'd0, "R6");
      step(1'b1, 16'hC001, 8'd7, 1'b1, 8'd3, 1'b1, "R11");
      step(1'b1, 16'hE001, 8'd0, 1'b1, 8'd3, 1'b1, "R11");
      step(1'b1, 16'hA000, 8'd0, 1'b1, 8'd3, 1'b1, "R12 miss write");
      wr(16'hD000, 8'd0, "R12");
      wr(16'hC100, 8'd0, "R12");
      wr(16'hC0FE, 8'd0, "R12 mirror");
      // R4 disable
      ln_strobe(8'd3, 1'b1, "R4 pre");
      wr(16'hE000, 8'd0, "R4");
      wr(16'hC000, 8'd0, "R4");
      ln_strobe(8'd4, 1'b1, "R4");
      ln_strobe(8'd0, 1'b1, "R4");
      // random phase
      for (int i = 0; i < 5000; i++) begin
         bit          w, s, r;
         logic [15:0] a;
         logic [7:0]  d, ln;
         w  = ($urandom_range(0, 99) < 20);
         a  = pool[$urandom_range(0, 11)];
         if ($urandom_range(0, 3) == 0) a = a | 16'($urandom_range(0, 127) << 1);
         if ($urandom_range(0, 4) == 0) a = 16'hE001;
         d  = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 6));
         s  = ($urandom_range(0, 99) < 60);
         ln = ($urandom_range(0, 5) == 0) ? 8'd0 : 8'($urandom);
         r  = ($urandom_range(0, 99) < 85);
         step(w, a, d, s, ln, r, "R9 random");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule